// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block collects single-cycle event pulses from a serial bus controller core and turns them into one level interrupt for the processor. Each event sets its own sticky status bit. A status bit stays set until software writes a one to it. A mask of enabled sources gates which status bits can raise the interrupt. The interrupt output is a registered OR of the status bits that are both set and enabled.

Software reaches the unit through a simple synchronous register port with an address, a write strobe, write data and combinational read data. The mask is never written directly. One write-only register sets mask bits and another clears them. Status bits are cleared by writing ones. Because of this, no register update needs a read-modify-write sequence.

Ten bit positions exist. Nine of them carry events, and position 8 is a hole that can never be set.

Top module: `irq_event_unit`

## Requirements
- R1: After reset the status bits, the mask bits and `irq_o` are all zero.
- R2: A pulse on `evt_i[n]` sets status bit n at the next clock edge, and the bit stays set afterwards. The bit meanings are: 0 transfer complete, 1 data threshold, 2 no-acknowledge, 3 timeout, 4 slave ready, 5 receive overflow, 6 transmit overflow, 7 receive underflow, 9 arbitration lost.
- R3: A write to the status register at address 0x10 clears each status bit whose write-data bit is one. Status bits whose write-data bit is zero keep their value.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R5: A write to address 0x24 sets each mask bit whose write-data bit is one. The other mask bits keep their value.
- R6: A write to address 0x28 clears each mask bit whose write-data bit is one. The other mask bits keep their value.
- R7: Reading address 0x10 returns the status bits in bits 9:0, and reading address 0x20 returns the mask. Reading 0x24 or 0x28 returns zero.
- R8: `irq_o` is a register. It equals the OR of (status AND mask) as sampled at the previous clock edge, so it changes one cycle after the status or the mask changes.
- R9: A status bit latches its event even while its mask bit is zero. A masked bit does not raise `irq_o`.
- R10: Bit position 8 is unused. Its event input, its status write and its mask writes have no effect, and it always reads as zero in both the status and the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 10 | Event pulses, one per bit position |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Level interrupt request |

## Verification
There are two kinds of internal error:
- A status or mask bit that holds a wrong value shows up in the read data the moment software addresses that register. It also shows on `irq_o` one cycle later, but only when the matching bit in the other vector is set.
- Errors in priority or latency are invisible in steady state. The same-cycle collision between an event and a clear is therefore driven on purpose. The interrupt is sampled in the cycle right after a clear, where a combinational or off-by-one output would already differ from the registered value.

Bit 8 is poked through every write path and every event path, and then read back, so that a hole accidentally filled in would appear as a one.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
   localparam int unsigned SRC_COUNT    = 10;
   localparam int unsigned OFF_STATUS   = 'h10;
   localparam int unsigned OFF_MASK     = 'h20;
   localparam int unsigned OFF_ENABLE   = 'h24;
   localparam int unsigned OFF_DISABLE  = 'h28;
   // positions that carry an event; position 8 is a hole
   localparam logic [SRC_COUNT-1:0] SRC_PRESENT = 10'h2FF;

   localparam int unsigned EV_DONE      = 0;
   localparam int unsigned EV_THRESHOLD = 1;
   localparam int unsigned EV_NO_ACK    = 2;
   localparam int unsigned EV_TIMEOUT   = 3;
   localparam int unsigned EV_TGT_READY = 4;
   localparam int unsigned EV_RX_OVER   = 5;
   localparam int unsigned EV_TX_OVER   = 6;
   localparam int unsigned EV_RX_UNDER  = 7;
   localparam int unsigned EV_ARB_LOSS  = 9;
endpackage

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   // set has priority over clear (R4)
   always_ff @(posedge clk) begin
      if (!rst_n)      q_o <= 1'b0;
      else if (set_i)  q_o <= 1'b1;
      else if (clr_i)  q_o <= 1'b0;
   end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int unsigned          NUM_SRC   = 10,
   parameter logic [NUM_SRC-1:0]   SRC_VALID = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_we,
   input  logic               clr_we,
   input  logic [NUM_SRC-1:0] bits_i,
   output logic [NUM_SRC-1:0] mask_o
);
   logic [NUM_SRC-1:0] set_v, clr_v;

   assign set_v = set_we ? bits_i : '0;
   assign clr_v = clr_we ? bits_i : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) mask_o <= '0;
      else        mask_o <= ((mask_o | set_v) & ~clr_v) & SRC_VALID;
   end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
   parameter int unsigned        ADDR_W  = 8,
   parameter int unsigned        DATA_W  = 32,
   parameter int unsigned        NUM_SRC = 10,
   parameter logic [ADDR_W-1:0]  A_STAT  = 8'h10,
   parameter logic [ADDR_W-1:0]  A_MASK  = 8'h20
) (
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [NUM_SRC-1:0] status_i,
   input  logic [NUM_SRC-1:0] mask_i,
   output logic [DATA_W-1:0]  rdata_o
);
   // write-only and unmapped addresses fall to zero
   always_comb begin
      rdata_o = '0;
      if (addr_i == A_STAT)      rdata_o = DATA_W'(status_i);
      else if (addr_i == A_MASK) rdata_o = DATA_W'(mask_i);
   end
endmodule

// File: rtl/irq_event_unit.sv
module irq_event_unit #(
   parameter int unsigned                NUM_SRC   = irq_unit_pkg::SRC_COUNT,
   parameter int unsigned                ADDR_W    = 8,
   parameter int unsigned                DATA_W    = 32,
   parameter logic [NUM_SRC-1:0]         SRC_VALID = irq_unit_pkg::SRC_PRESENT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_we,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq_o
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(irq_unit_pkg::OFF_STATUS);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(irq_unit_pkg::OFF_MASK);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(irq_unit_pkg::OFF_ENABLE);
   localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(irq_unit_pkg::OFF_DISABLE);

   if (NUM_SRC > DATA_W) begin : g_chk_width
      $error("irq_event_unit: NUM_SRC exceeds DATA_W");
   end
   if (ADDR_W < 6) begin : g_chk_addr
      $error("irq_event_unit: ADDR_W too narrow for the register offsets");
   end

   logic [NUM_SRC-1:0] status_q;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] wbits;
   logic               wr_stat, wr_en, wr_dis;

   assign wbits   = bus_wdata[NUM_SRC-1:0];
   assign wr_stat = bus_we && (bus_addr == A_STAT);
   assign wr_en   = bus_we && (bus_addr == A_EN);
   assign wr_dis  = bus_we && (bus_addr == A_DIS);

   if (DATA_W > NUM_SRC) begin : g_wide
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];
   end

   logic unused_evt_holes;
   assign unused_evt_holes = ^(evt_i & ~SRC_VALID) ^ ^(wbits & ~SRC_VALID);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (SRC_VALID[i]) begin : g_live
         irq_sticky_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (evt_i[i]),
            .clr_i (wr_stat && wbits[i]),
            .q_o   (status_q[i])
         );
      end else begin : g_hole
         assign status_q[i] = 1'b0;
      end
   end

   irq_mask_reg #(.NUM_SRC(NUM_SRC), .SRC_VALID(SRC_VALID)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (wr_en),
      .clr_we (wr_dis),
      .bits_i (wbits),
      .mask_o (mask_q)
   );

   irq_read_mux #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC),
      .A_STAT(A_STAT), .A_MASK(A_MASK)
   ) u_rd (
      .addr_i   (bus_addr),
      .status_i (status_q),
      .mask_i   (mask_q),
      .rdata_o  (bus_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= |(status_q & mask_q);
   end
endmodule

// File: rtl/irq_event_unit_chk.sv
module irq_event_unit_chk #(
   parameter int unsigned        NUM_SRC   = 10,
   parameter int unsigned        ADDR_W    = 8,
   parameter int unsigned        DATA_W    = 32,
   parameter logic [NUM_SRC-1:0] SRC_VALID = '1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] evt_i,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               bus_we,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic               irq_o,
   input logic [NUM_SRC-1:0] status_q,
   input logic [NUM_SRC-1:0] mask_q
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(irq_unit_pkg::OFF_STATUS);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(irq_unit_pkg::OFF_ENABLE);
   localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(irq_unit_pkg::OFF_DISABLE);

   logic [NUM_SRC-1:0] ev_v, wr_v;
   logic               st_wr, en_wr, dis_wr;

   assign ev_v   = evt_i & SRC_VALID;
   assign wr_v   = bus_wdata[NUM_SRC-1:0] & SRC_VALID;
   assign st_wr  = bus_we && (bus_addr == A_STAT);
   assign en_wr  = bus_we && (bus_addr == A_EN);
   assign dis_wr = bus_we && (bus_addr == A_DIS);

   assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_v != '0) |=> ((status_q & $past(ev_v)) == $past(ev_v)));

   assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !st_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

   assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
      st_wr |=> ((status_q & $past(wr_v & ~ev_v)) == '0));

   assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && ((ev_v & wr_v) != '0)) |=>
         ((status_q & $past(ev_v & wr_v)) == $past(ev_v & wr_v)));

   assert_enable_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      en_wr |=> ((mask_q & $past(wr_v)) == $past(wr_v)));

   assert_disable_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dis_wr |=> ((mask_q & $past(wr_v)) == '0));

   assert_irq_registered_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (|$past(status_q & mask_q)));

   assert_hole_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q | mask_q) & ~SRC_VALID) == '0);
endmodule

bind irq_event_unit irq_event_unit_chk #(
   .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_VALID(SRC_VALID)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_i     (evt_i),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .irq_o     (irq_o),
   .status_q  (status_q),
   .mask_q    (mask_q)
);

// File: tb/irq_event_unit_test.sv
module irq_event_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_STAT = 8'h10;
   localparam logic [7:0] A_MASK = 8'h20;
   localparam logic [7:0] A_EN   = 8'h24;
   localparam logic [7:0] A_DIS  = 8'h28;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  evt_i = '0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   irq_event_unit uut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       tag;
   } sb_item_t;

   sb_item_t    sb_q[$];
   sb_item_t    mon_item;
   logic [31:0] mon_act;
   int          n_checks = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   // monitor: compare in the middle of the cycle the item was queued
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         mon_item = sb_q.pop_front();
         mon_act  = mon_item.is_irq ? {31'b0, irq_o} : bus_rdata;
         n_checks++;
         if (mon_act !== mon_item.exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", mon_item.tag, mon_act, mon_item.exp);
         end
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic pulse(input logic [9:0] m);
      evt_i = m;
      tick();
      evt_i = '0;
   endtask

   task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      sb_item_t it;
      bus_addr = a;
      it.is_irq = 1'b0; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      tick();
   endtask

   task automatic exp_irq(input logic e, input string tag);
      sb_item_t it;
      it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
      sb_q.push_back(it);
      tick();
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      exp_rd(A_STAT, 32'h0, "R1 status after reset");
      exp_rd(A_MASK, 32'h0, "R1 mask after reset");
      exp_irq(1'b0, "R1 irq after reset");

      pulse(10'h201);
      exp_rd(A_STAT, 32'h201, "R2 done and arbitration bits latch");
      exp_irq(1'b0, "R9 masked events raise no irq");
      pulse(10'h0FE);
      exp_rd(A_STAT, 32'h2FF, "R2 remaining sources latch and stay");

      pulse(10'h100);
      exp_rd(A_STAT, 32'h2FF, "R10 event on hole ignored");
      wr(A_STAT, 32'h0000_000F);
      exp_rd(A_STAT, 32'h2F0, "R3 write-one clears low nibble");
      wr(A_STAT, 32'h0);
      exp_rd(A_STAT, 32'h2F0, "R3 write of zeros changes nothing");

      // event on bit 4 and clear of bits 4 and 5 in the same cycle
      bus_we = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h30; evt_i = 10'h010;
      tick();
      bus_we = 1'b0; bus_wdata = '0; evt_i = '0;
      exp_rd(A_STAT, 32'h2D0, "R4 event beats clear on same bit");

      wr(A_EN, 32'h010);
      exp_rd(A_MASK, 32'h010, "R5 enable sets mask bit 4");
      exp_rd(A_EN, 32'h0, "R7 enable register reads zero");
      exp_rd(A_DIS, 32'h0, "R7 disable register reads zero");
      exp_irq(1'b1, "R8 irq on enabled pending source");

      wr(A_STAT, 32'h010);
      exp_irq(1'b1, "R8 irq still high the cycle after clear");
      exp_irq(1'b0, "R8 irq low one cycle later");

      wr(A_EN, 32'h300);
      exp_rd(A_MASK, 32'h210, "R10 R5 enable keeps bit 4, hole stays zero");
      exp_irq(1'b1, "R8 arbitration bit now enabled");

      wr(A_DIS, 32'h200);
      exp_rd(A_MASK, 32'h010, "R6 disable clears only bit 9");
      exp_irq(1'b0, "R6 irq drops after disable");

      pulse(10'h002);
      exp_rd(A_STAT, 32'h2C2, "R9 masked source still latches");
      exp_irq(1'b0, "R9 masked source raises no irq");

      wr(A_DIS, 32'h100);
      exp_rd(A_MASK, 32'h010, "R10 disable on hole leaves mask");
      wr(A_STAT, 32'h3FF);
      exp_rd(A_STAT, 32'h0, "R3 clear all sources");

      tick();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule